// File: doc/BRIEF.md
# Eight-Pin GPIO Port Register File with Masked Writes

This block holds the control state of one eight-pin general-purpose I/O port and drives its pads. For each pin it keeps three control bits: an enable that places the pin under GPIO control, a drive enable that makes the pin an output, and the level the pin drives when it is an output. The pin inputs are brought in through a two-stage synchronizer and read from a read-only input register. The block sits on a simple register bus with an address, a write strobe, 32-bit write data and combinational read data.

Each control register can be reached at two addresses. A plain write replaces all eight bits. A masked write, at the plain address plus a fixed alias offset, carries a per-pin write mask in data bits 15:8 and the new values in bits 7:0. Software can therefore change a single pin with one bus write and no read-modify-write. The pad stage gates the output driver with the GPIO enable and the drive enable. It also reports each pin's direction as not-GPIO, input or output.

Top module: `gpio_port_regs`

## Requirements
- R1: During and after reset the enable, drive-enable and level registers are all zero. Every pad driver is off and every pin's direction code is 2'b00.
- R2: A plain write to offset 0x00 (enable), 0x10 (drive enable) or 0x20 (level) replaces all eight bits with write data bits 7:0 at the next clock edge. Reading these offsets returns the register in bits 7:0 and zero in bits 31:8.
- R3: A write to a masked alias (plain offset plus MASK_OFS, 0x80 by default) updates only the pins whose bit is 1 in data bits 15:8, taking the value from data bits 7:0. Pins whose mask bit is 0 keep their value, so a mask of zero changes nothing.
- R4: A read of a masked alias returns the same value as the plain register in bits 7:0 and zero in bits 31:8.
- R5: The input register at offset 0x30 is read-only. A value applied to pad_in appears there after exactly two rising clock edges, and a write to 0x30 changes no register.
- R6: pad_en for a pin is 1 exactly when both its enable bit and its drive-enable bit are 1. pad_out carries the level bit when pad_en is 1 and is 0 otherwise.
- R7: pin_dir holds two bits per pin, pin i at bits 2i+1:2i. The code is 2'b00 when the enable bit is clear, 2'b01 when enabled with drive enable clear (input), and 2'b10 when enabled with drive enable set (output).
- R8: Addresses that match no register read as zero. A write to such an address, including the masked alias of the input register, changes no register.
- R9: If the level of a pin is written before its drive enable is set, the pad shows that level in the first cycle its driver turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data; bits 15:8 are the mask for masked aliases |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Pin levels from the pads, asynchronous |
| pad_out | output | 8 | Level driven onto each pad |
| pad_en | output | 8 | Tri-state driver enable per pad |
| pin_dir | output | 16 | Direction code per pin, two bits each |

## Verification
A wrong bit in any control register reaches pad_en, pad_out and pin_dir in the same cycle it is stored. A read of either alias shows it at once, so a faulty mask merge or decode shows up one edge after the bad write. A synchronizer with the wrong depth shows in the input register one cycle too early or too late after a pad change. The bench therefore keeps its own model of the three registers and the two-deep input pipeline and compares all outputs and the read data for the current address on every cycle, including during random write storms to mapped, aliased and unmapped addresses.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   // direction code reported per pin
   typedef enum logic [1:0] {
      DIR_NONE = 2'b00,
      DIR_IN   = 2'b01,
      DIR_OUT  = 2'b10
   } pin_dir_e;

   // control registers in address order; index selects stride slot
   localparam int unsigned NUM_CTRL   = 3;
   localparam int unsigned IDX_EN     = 0;
   localparam int unsigned IDX_DRV    = 1;
   localparam int unsigned IDX_LVL    = 2;
   localparam int unsigned REG_STRIDE = 16;
   localparam int unsigned OFS_INPUT  = NUM_CTRL * REG_STRIDE;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_port_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned MASK_OFS = 'h80
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_CTRL-1:0] plain_hit,
   output logic [NUM_CTRL-1:0] mask_hit,
   output logic                in_hit
);
   if (MASK_OFS <= OFS_INPUT) begin : g_bad_ofs
      $error("MASK_OFS must lie above the plain register window");
   end
   if (MASK_OFS + OFS_INPUT >= (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too narrow for masked aliases");
   end

   for (genvar r = 0; r < NUM_CTRL; r++) begin : g_hit
      assign plain_hit[r] = (addr == ADDR_W'(r * REG_STRIDE));
      assign mask_hit[r]  = (addr == ADDR_W'(MASK_OFS + r * REG_STRIDE));
   end

   assign in_hit = (addr == ADDR_W'(OFS_INPUT));
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
   parameter int unsigned PIN_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               plain_we,
   input  logic               mask_we,
   input  logic [2*PIN_W-1:0] wdata,
   output logic [PIN_W-1:0]   q
);
   logic [PIN_W-1:0] new_val;
   logic [PIN_W-1:0] sel_mask;

   assign new_val  = wdata[PIN_W-1:0];
   assign sel_mask = wdata[2*PIN_W-1:PIN_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (plain_we) begin
         q <= new_val;
      end else if (mask_we) begin
         q <= (q & ~sel_mask) | (new_val & sel_mask);
      end
   end

   // R3
   keep_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we && !plain_we |=> ((q ^ $past(q)) & ~$past(sel_mask)) == '0);

   // R3
   take_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we && !plain_we |=> ((q ^ $past(new_val)) & $past(sel_mask)) == '0);

   // R2
   plain_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      plain_we |=> q == $past(new_val));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned PIN_W  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] d,
   output logic [PIN_W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("synchronizer needs at least two stages");
   end

   logic [STAGES-1:0][PIN_W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_W = 8
) (
   input  logic [PIN_W-1:0]   en_q,
   input  logic [PIN_W-1:0]   drv_q,
   input  logic [PIN_W-1:0]   lvl_q,
   output logic [PIN_W-1:0]   pad_en,
   output logic [PIN_W-1:0]   pad_out,
   output logic [2*PIN_W-1:0] pin_dir
);
   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      pin_dir_e code;
      always_comb begin
         if (!en_q[i])      code = DIR_NONE;
         else if (drv_q[i]) code = DIR_OUT;
         else               code = DIR_IN;
      end
      assign pad_en[i]           = en_q[i] & drv_q[i];
      assign pad_out[i]          = pad_en[i] & lvl_q[i];
      assign pin_dir[2*i +: 2]   = code;
   end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MASK_OFS    = 'h80,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [PIN_W-1:0]     pad_in,
   output logic [PIN_W-1:0]     pad_out,
   output logic [PIN_W-1:0]     pad_en,
   output logic [2*PIN_W-1:0]   pin_dir
);
   localparam int unsigned WD_W = 2 * PIN_W;

   if (WD_W > DATA_W) begin : g_bad_width
      $error("data bus must hold mask and value fields");
   end

   logic [NUM_CTRL-1:0]            plain_hit;
   logic [NUM_CTRL-1:0]            mask_hit;
   logic                           in_hit;
   logic [NUM_CTRL-1:0][PIN_W-1:0] ctrl_q;
   logic [PIN_W-1:0]               in_q;

   gpio_addr_decode #(
      .ADDR_W   (ADDR_W),
      .MASK_OFS (MASK_OFS)
   ) i_dec (
      .addr      (bus_addr),
      .plain_hit (plain_hit),
      .mask_hit  (mask_hit),
      .in_hit    (in_hit)
   );

   for (genvar r = 0; r < NUM_CTRL; r++) begin : g_ctrl
      gpio_mask_reg #(.PIN_W(PIN_W)) i_reg (
         .clk      (clk),
         .rst_n    (rst_n),
         .plain_we (bus_we & plain_hit[r]),
         .mask_we  (bus_we & mask_hit[r]),
         .wdata    (bus_wdata[WD_W-1:0]),
         .q        (ctrl_q[r])
      );
   end

   if (DATA_W > WD_W) begin : g_hi_sink
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WD_W];
   end

   gpio_in_sync #(
      .PIN_W  (PIN_W),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_q)
   );

   gpio_pad_drv #(.PIN_W(PIN_W)) i_pad (
      .en_q    (ctrl_q[IDX_EN]),
      .drv_q   (ctrl_q[IDX_DRV]),
      .lvl_q   (ctrl_q[IDX_LVL]),
      .pad_en  (pad_en),
      .pad_out (pad_out),
      .pin_dir (pin_dir)
   );

   always_comb begin
      bus_rdata = '0;
      for (int r = 0; r < NUM_CTRL; r++) begin
         if (plain_hit[r] || mask_hit[r]) bus_rdata[PIN_W-1:0] = ctrl_q[r];
      end
      if (in_hit) bus_rdata[PIN_W-1:0] = in_q;
   end

   logic any_hit;
   assign any_hit = (|plain_hit) | (|mask_hit);

   // R1
   reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ctrl_q == '0);

   // R8
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && !any_hit |=> $stable(ctrl_q));

   // R5
   input_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && in_hit |=> $stable(ctrl_q));

   for (genvar i = 0; i < PIN_W; i++) begin : g_pin_chk
      // R7
      dir_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(pin_dir[2*i +: 2]));
      // R6
      drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pad_en[i] == (pin_dir[2*i +: 2] == DIR_OUT));
      // R6
      quiet_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pad_en[i] |-> !pad_out[i]);
   end
endmodule

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;
   localparam int PW = 8;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int MOFS = 'h80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [PW-1:0] pad_in = '0;
   logic [PW-1:0] pad_out;
   logic [PW-1:0] pad_en;
   logic [2*PW-1:0] pin_dir;

   int checks = 0;
   int errors = 0;
   bit monitor_on = 0;
   bit done = 0;

   // reference model state
   logic [PW-1:0] m_en = '0, m_drv = '0, m_lvl = '0, m_s1 = '0, m_s2 = '0;

   always #4 clk = ~clk;

   gpio_port_regs i_gpio_port_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_en(pad_en), .pin_dir(pin_dir)
   );

   function automatic logic [PW-1:0] merge(logic [PW-1:0] old, logic [DW-1:0] w, bit masked);
      if (!masked) return w[7:0];
      return (old & ~w[15:8]) | (w[7:0] & w[15:8]);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         if (bus_we) begin
            case (int'(bus_addr))
               'h00: m_en  = merge(m_en,  bus_wdata, 0);
               'h10: m_drv = merge(m_drv, bus_wdata, 0);
               'h20: m_lvl = merge(m_lvl, bus_wdata, 0);
               MOFS + 'h00: m_en  = merge(m_en,  bus_wdata, 1);
               MOFS + 'h10: m_drv = merge(m_drv, bus_wdata, 1);
               MOFS + 'h20: m_lvl = merge(m_lvl, bus_wdata, 1);
               default: ;
            endcase
         end
         m_s2 = m_s1;
         m_s1 = pad_in;
      end
   end

   function automatic logic [DW-1:0] exp_rd(int a);
      case (a)
         'h00, MOFS + 'h00: return {24'h0, m_en};
         'h10, MOFS + 'h10: return {24'h0, m_drv};
         'h20, MOFS + 'h20: return {24'h0, m_lvl};
         'h30: return {24'h0, m_s2};
         default: return '0;
      endcase
   endfunction

   function automatic string rd_tag(int a);
      if (a == 'h00 || a == 'h10 || a == 'h20) return "R2";
      if (a == MOFS || a == MOFS + 'h10 || a == MOFS + 'h20) return "R4";
      if (a == 'h30) return "R5";
      return "R8";
   endfunction

   function automatic logic [2*PW-1:0] exp_dir();
      logic [2*PW-1:0] d;
      for (int i = 0; i < PW; i++)
         d[2*i +: 2] = !m_en[i] ? 2'b00 : (m_drv[i] ? 2'b10 : 2'b01);
      return d;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (monitor_on) begin
         check(bus_rdata == exp_rd(int'(bus_addr)), rd_tag(int'(bus_addr)), bus_rdata, exp_rd(int'(bus_addr)));
         check(pad_en == (m_en & m_drv), "R6 pad_en", 32'(pad_en), 32'(m_en & m_drv));
         check(pad_out == (m_en & m_drv & m_lvl), "R6 pad_out", 32'(pad_out), 32'(m_en & m_drv & m_lvl));
         check(pin_dir == exp_dir(), "R7", 32'(pin_dir), 32'(exp_dir()));
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(int a, logic [31:0] exp, string tag);
      bus_addr = AW'(a);
      #1;
      check(bus_rdata == exp, tag, bus_rdata, exp);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      rd('h00, 0, "R1 en"); rd('h10, 0, "R1 drv"); rd('h20, 0, "R1 lvl");
      check(pad_en == 0 && pin_dir == 0, "R1 pads", {pad_en, pin_dir}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      monitor_on = 1;

      // R2 plain writes replace all bits, upper read bits zero
      wr('h00, 32'hFFFF_FFFF);
      rd('h00, 32'h0000_00FF, "R2 en");
      wr('h10, 32'h0000_00A5);
      rd('h10, 32'h0000_00A5, "R2 drv");

      // R3 masked writes on level register
      wr(MOFS + 'h20, 32'h0000_0F05);
      rd('h20, 32'h05, "R3 low nibble");
      wr(MOFS + 'h20, 32'h0000_F0FF);
      rd('h20, 32'hF5, "R3 high nibble");
      wr(MOFS + 'h20, 32'h0000_00AA);
      rd('h20, 32'hF5, "R3 zero mask");

      // R9 level first, then drive enable for pin 6
      wr(MOFS + 'h20, 32'h0000_4040);
      check(pad_en[6] == 0, "R9 pre", 32'(pad_en[6]), 0);
      wr(MOFS + 'h10, 32'h0000_4040);
      check(pad_en[6] == 1 && pad_out[6] == 1, "R9 first cycle", {pad_en[6], pad_out[6]}, 2'b11);

      // R4 masked alias reads
      rd(MOFS + 'h10, 32'hE5, "R4 drv alias");
      rd(MOFS, 32'hFF, "R4 en alias");

      // R7 clear enable for pin 0 with masked write
      wr(MOFS, 32'h0000_0100);
      check(pin_dir[1:0] == 2'b00, "R7 not gpio", 32'(pin_dir[1:0]), 0);
      check(pin_dir[3:2] == 2'b01, "R7 input", 32'(pin_dir[3:2]), 1);

      // R5 two-edge synchronizer latency and read-only input
      @(negedge clk);
      pad_in = 8'h3C;
      bus_addr = AW'('h30);
      @(negedge clk); #1;
      check(bus_rdata == 0, "R5 one edge", bus_rdata, 0);
      @(negedge clk); #1;
      check(bus_rdata == 32'h3C, "R5 two edges", bus_rdata, 32'h3C);
      wr('h30, 32'hFFFF_FFFF);
      rd('h00, 32'hFE, "R5 write ignored");

      // R8 unmapped writes and reads
      wr('h40, 32'hFFFF_FFFF);
      wr(MOFS + 'h30, 32'hFFFF_FFFF);
      wr('h04, 32'hFFFF_0000);
      rd('h40, 0, "R8 read");
      rd('h00, 32'hFE, "R8 en kept");
      rd('h20, 32'hF5, "R8 lvl kept");

      // random traffic checked by the monitor
      for (int n = 0; n < 600; n++) begin
         int a;
         @(negedge clk);
         case ($urandom_range(0, 9))
            0: a = 'h00; 1: a = 'h10; 2: a = 'h20; 3: a = 'h30;
            4: a = MOFS; 5: a = MOFS + 'h10; 6: a = MOFS + 'h20;
            7: a = MOFS + 'h30; 8: a = 'h08; default: a = 'h20;
         endcase
         bus_addr = AW'(a);
         bus_wdata = $urandom;
         bus_we = $urandom_range(0, 1) == 1;
         pad_in = PW'($urandom);
      end
      @(negedge clk);
      bus_we = 1'b0;
      repeat (4) @(negedge clk);
      #3;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule